// File: doc/BRIEF.md
# Aligned Load-Store Unit

This block executes one memory access at a time on behalf of a processor pipeline. A request carries a base register value, a signed 16-bit displacement, an access width (byte, halfword or word), a store/load flag, an extension select and, for stores, the register data. The unit adds the displacement to the base to form a byte address. It checks that the address suits the access width. It then drives a 32-bit data memory port that has per-byte write enables and a read latency of one cycle.

Loads return the addressed byte or halfword in the low bits of the result, filled above with zeros or copies of the sign bit. A word load returns all 32 bits unchanged. Stores place the data in the byte lanes the address selects and assert only the enables of the bytes written. A halfword at an odd address, or a word at an address that is not a multiple of four, never reaches memory. The unit reports it as an alignment fault together with the offending address.

Top module: `lsu_core`

## Requirements
- R1: The access address is `req_base` plus `req_offset` sign-extended to 32 bits, carried modulo 2^32. It appears on `mem_addr` as a full byte address.
- R2: `req_size` encodes the width as 0 = byte, 1 = halfword, 2 = word. The value 3 is handled exactly like a word.
- R3: Byte accesses are allowed at any address. Lanes are little-endian: address bits [1:0] = k select data bits [8k+7:8k].
- R4: A halfword with address bit 0 set, or a word with either of address bits [1:0] set, is misaligned. This rule holds for loads and stores alike.
- R5: A misaligned request raises `fault_valid` for exactly one cycle, the cycle after it is accepted, with `fault_addr` equal to the computed address. It issues no memory request, produces no `ld_valid`, and leaves memory contents unchanged.
- R6: A store replicates a byte to all four lanes and a halfword to both halves of `mem_wdata`. `mem_be` has one bit per byte lane, with bit k for bits [8k+7:8k], set only for the bytes written. A word store drives the data unchanged with all enables set.
- R7: A byte or halfword load zero-extends when `req_signed` is 0 and sign-extends when it is 1. A word load ignores `req_signed`.
- R8: An accepted aligned request drives `mem_req_valid` for exactly the one following cycle. Memory presents `mem_rdata` in the cycle after that. `ld_valid` and `ld_data` appear one cycle later still, for one cycle.
- R9: `req_ready` is 1 out of reset and whenever no access is in flight. It is 0 from the memory request cycle until the load result is delivered, or until the cycle after the request cycle for a store.
- R10: A new request may be accepted in the same cycle that the previous load result is delivered on `ld_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access width code |
| req_signed | input | 1 | Sign-extend a narrow load |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data, right-justified |
| mem_req_valid | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_be | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | Read word, valid one cycle after the request |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| fault_valid | output | 1 | Alignment fault pulse |
| fault_addr | output | 32 | Address that faulted |

## Verification
Two functions can fall in the same cycle. One is the delivery of a load result on `ld_valid`. The other is the acceptance of the next request, because the unit returns to idle in the very cycle it presents the result. The bench provokes this by holding a second request valid while the first load is still waiting for memory data. It judges the cycle by requiring `req_ready` to be low before the result and high together with `ld_valid`, with the correct first result. The second access must then appear on the memory port one cycle later and return its own data.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    // access width codes as seen on req_size
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_ALT  = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_RESP = 2'd2
    } state_e;

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int LANE_W = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  lsu_pkg::size_e    size,
    output logic [ADDR_W-1:0] ea,
    output logic              misaligned
);
    import lsu_pkg::*;

    logic [ADDR_W-1:0] off_ext;

    assign off_ext = {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
    assign ea      = base + off_ext;

    always_comb begin
        case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = ea[0];
            default: misaligned = |ea[LANE_W-1:0];
        endcase
    end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 2
) (
    input  logic [DATA_W-1:0]   wdata,
    input  lsu_pkg::size_e      size,
    input  logic [LANE_W-1:0]   lane,
    output logic [DATA_W-1:0]   lane_data,
    output logic [DATA_W/8-1:0] be
);
    import lsu_pkg::*;

    localparam int NLANES = DATA_W / 8;

    logic is_byte;
    logic is_half;

    assign is_byte = (size == SZ_BYTE);
    assign is_half = (size == SZ_HALF);

    for (genvar k = 0; k < NLANES; k++) begin : g_lane
        assign lane_data[8*k +: 8] = is_byte ? wdata[7:0] :
                                     is_half ? wdata[8*(k%2) +: 8] :
                                               wdata[8*k +: 8];
        assign be[k] = is_byte ? (lane == LANE_W'(k)) :
                       is_half ? (lane[LANE_W-1:1] == (LANE_W-1)'(k/2)) :
                                 1'b1;
    end

endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 2
) (
    input  logic [DATA_W-1:0] rdata,
    input  lsu_pkg::size_e    size,
    input  logic [LANE_W-1:0] lane,
    input  logic              sgn,
    output logic [DATA_W-1:0] data
);
    import lsu_pkg::*;

    logic [DATA_W-1:0] shifted;
    logic [7:0]        byte_v;
    logic [15:0]       half_v;

    assign shifted = rdata >> {lane, 3'b000};
    assign byte_v  = shifted[7:0];
    assign half_v  = shifted[15:0];

    always_comb begin
        case (size)
            SZ_BYTE: data = {{(DATA_W-8){sgn & byte_v[7]}}, byte_v};
            SZ_HALF: data = {{(DATA_W-16){sgn & half_v[15]}}, half_v};
            default: data = rdata;
        endcase
    end

endmodule

// File: rtl/lsu_core.sv
module lsu_core #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_store,
    input  logic [1:0]          req_size,
    input  logic                req_signed,
    input  logic [ADDR_W-1:0]   req_base,
    input  logic [OFF_W-1:0]    req_offset,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                mem_req_valid,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                ld_valid,
    output logic [DATA_W-1:0]   ld_data,
    output logic                fault_valid,
    output logic [ADDR_W-1:0]   fault_addr
);
    import lsu_pkg::*;

    localparam int NLANES = DATA_W / 8;
    localparam int LANE_W = $clog2(NLANES);

    typedef struct packed {
        state_e              state;
        logic                store;
        size_e               size;
        logic                sgn;
        logic [ADDR_W-1:0]   ea;
        logic [NLANES-1:0]   be;
        logic [DATA_W-1:0]   wdata;
        logic                ld_valid;
        logic [DATA_W-1:0]   ld_data;
        logic                fault_valid;
        logic [ADDR_W-1:0]   fault_addr;
    } regs_t;

    regs_t r_d, r_q;

    size_e             size_in;
    logic [ADDR_W-1:0] ea_w;
    logic              misaligned_w;
    logic [DATA_W-1:0] lane_data_w;
    logic [NLANES-1:0] be_w;
    logic [DATA_W-1:0] ext_w;

    assign size_in = size_e'(req_size);

    lsu_agen #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .LANE_W (LANE_W)
    ) u_agen (
        .base       (req_base),
        .offset     (req_offset),
        .size       (size_in),
        .ea         (ea_w),
        .misaligned (misaligned_w)
    );

    lsu_store_lanes #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_store (
        .wdata     (req_wdata),
        .size      (size_in),
        .lane      (ea_w[LANE_W-1:0]),
        .lane_data (lane_data_w),
        .be        (be_w)
    );

    lsu_load_extend #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_ext (
        .rdata (mem_rdata),
        .size  (r_q.size),
        .lane  (r_q.ea[LANE_W-1:0]),
        .sgn   (r_q.sgn),
        .data  (ext_w)
    );

    always_comb begin
        r_d             = r_q;
        r_d.ld_valid    = 1'b0;
        r_d.fault_valid = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (misaligned_w) begin
                        r_d.fault_valid = 1'b1;
                        r_d.fault_addr  = ea_w;
                    end else begin
                        r_d.state = ST_MEM;
                        r_d.store = req_store;
                        r_d.size  = size_in;
                        r_d.sgn   = req_signed;
                        r_d.ea    = ea_w;
                        r_d.be    = be_w;
                        r_d.wdata = lane_data_w;
                    end
                end
            end
            ST_MEM: begin
                r_d.state = r_q.store ? ST_IDLE : ST_RESP;
            end
            ST_RESP: begin
                r_d.state    = ST_IDLE;
                r_d.ld_valid = 1'b1;
                r_d.ld_data  = ext_w;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.state == ST_IDLE);
    assign mem_req_valid = (r_q.state == ST_MEM);
    assign mem_we        = r_q.store;
    assign mem_addr      = r_q.ea;
    assign mem_be        = r_q.be;
    assign mem_wdata     = r_q.wdata;
    assign ld_valid      = r_q.ld_valid;
    assign ld_data       = r_q.ld_data;
    assign fault_valid   = r_q.fault_valid;
    assign fault_addr    = r_q.fault_addr;

endmodule

// File: rtl/lsu_core_chk.sv
module lsu_core_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_ready,
    input logic                mem_req_valid,
    input logic                mem_we,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [DATA_W/8-1:0] mem_be,
    input logic                ld_valid,
    input logic                fault_valid
);

    // R5
    fault_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> !mem_req_valid && !ld_valid);

    // R5
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> !fault_valid || $past(req_ready));

    // R8
    mem_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R8
    ld_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_req_valid && !mem_we, 2));

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R4
    aligned_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (($countones(mem_be) == 1) ||
                           ($countones(mem_be) == 2 && !mem_addr[0]) ||
                           ($countones(mem_be) == 4 && mem_addr[1:0] == 2'b00)));

endmodule

bind lsu_core lsu_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/lsu_core_bench.sv
module lsu_core_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_signed = 1'b0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        mem_req_valid;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        ld_valid;
    logic [31:0] ld_data;
    logic        fault_valid;
    logic [31:0] fault_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_core u_lsu_core (.*);

    // memory model: 16 words, one-cycle read latency
    logic [31:0] mem [16];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= '0;
            mem[4]    <= 32'hA1B2_83F4;
            mem_rdata <= '0;
        end else if (mem_req_valid) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[5:2]];
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // returns at the negedge after the accepting edge
    task automatic send(bit st, logic [1:0] sz, bit sg, logic [31:0] base,
                        logic [15:0] off, logic [31:0] wd);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid  = 1'b1;
        req_store  = st;
        req_size   = sz;
        req_signed = sg;
        req_base   = base;
        req_offset = off;
        req_wdata  = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_load(string req, logic [1:0] sz, bit sg, logic [31:0] base,
                           logic [15:0] off, logic [31:0] ea, logic [3:0] be,
                           logic [31:0] exp);
        send(1'b0, sz, sg, base, off, '0);
        check({req, " R1 addr"}, mem_addr, ea);
        check({req, " R8 memreq"}, {31'd0, mem_req_valid & ~mem_we}, 32'd1);
        check({req, " R2 be"}, {28'd0, mem_be}, {28'd0, be});
        @(negedge clk);
        check({req, " R9 busy"}, {30'd0, req_ready, ld_valid}, 32'd0);
        @(negedge clk);
        check({req, " R8 ldvalid"}, {31'd0, ld_valid}, 32'd1);
        check({req, " data"}, ld_data, exp);
    endtask

    task automatic do_store(string req, logic [1:0] sz, logic [31:0] base,
                            logic [15:0] off, logic [31:0] wd, logic [31:0] ea,
                            logic [3:0] be, logic [31:0] exp_wd);
        send(1'b1, sz, 1'b0, base, off, wd);
        check({req, " R1 addr"}, mem_addr, ea);
        check({req, " R6 we"}, {31'd0, mem_req_valid & mem_we}, 32'd1);
        check({req, " R6 be"}, {28'd0, mem_be}, {28'd0, be});
        check({req, " R6 wdata"}, mem_wdata, exp_wd);
        @(negedge clk);
        check({req, " R9 ready"}, {31'd0, req_ready}, 32'd1);
    endtask

    task automatic do_fault(string req, bit st, logic [1:0] sz, logic [31:0] base,
                            logic [15:0] off, logic [31:0] ea);
        send(st, sz, 1'b0, base, off, 32'hDEAD_BEEF);
        check({req, " R5 fault"}, {30'd0, fault_valid, mem_req_valid}, 32'd2);
        check({req, " R5 faddr"}, fault_addr, ea);
        @(negedge clk);
        check({req, " R5 pulse"}, {29'd0, fault_valid, mem_req_valid, ld_valid}, 32'd0);
    endtask

    task automatic t_reset();
        check("R9 reset ready", {31'd0, req_ready}, 32'd1);
        check("R8 reset idle", {29'd0, mem_req_valid, ld_valid, fault_valid}, 32'd0);
    endtask

    task automatic t_byte_loads();
        do_load("R3 R7 lbu lane0", 2'd0, 1'b0, 32'h0C, 16'h0004, 32'h10, 4'b0001, 32'h0000_00F4);
        do_load("R7 lb lane0", 2'd0, 1'b1, 32'h0C, 16'h0004, 32'h10, 4'b0001, 32'hFFFF_FFF4);
        do_load("R3 lb lane1", 2'd0, 1'b1, 32'h11, 16'h0000, 32'h11, 4'b0010, 32'hFFFF_FF83);
        do_load("R3 lbu lane2", 2'd0, 1'b0, 32'h12, 16'h0000, 32'h12, 4'b0100, 32'h0000_00B2);
        do_load("R1 R3 lb lane3 negoff", 2'd0, 1'b1, 32'h20, 16'hFFF3, 32'h13, 4'b1000, 32'hFFFF_FFA1);
    endtask

    task automatic t_half_word_loads();
        do_load("R7 lhu low", 2'd1, 1'b0, 32'h10, 16'h0000, 32'h10, 4'b0011, 32'h0000_83F4);
        do_load("R7 lh low", 2'd1, 1'b1, 32'h10, 16'h0000, 32'h10, 4'b0011, 32'hFFFF_83F4);
        do_load("R7 lh high", 2'd1, 1'b1, 32'h10, 16'h0002, 32'h12, 4'b1100, 32'hFFFF_A1B2);
        do_load("R7 lhu high", 2'd1, 1'b0, 32'h14, 16'hFFFE, 32'h12, 4'b1100, 32'h0000_A1B2);
        do_load("R7 lw signed ignored", 2'd2, 1'b1, 32'h10, 16'h0000, 32'h10, 4'b1111, 32'hA1B2_83F4);
        do_load("R2 size3 as word", 2'd3, 1'b0, 32'h10, 16'h0000, 32'h10, 4'b1111, 32'hA1B2_83F4);
    endtask

    task automatic t_load_faults();
        do_fault("R4 lh odd", 1'b0, 2'd1, 32'h10, 16'h0003, 32'h13);
        do_fault("R4 lw off2", 1'b0, 2'd2, 32'h10, 16'h0002, 32'h12);
        do_fault("R4 lw off1", 1'b0, 2'd2, 32'h15, 16'hFFFC, 32'h11);
        do_fault("R4 size3 off2", 1'b0, 2'd3, 32'h12, 16'h0000, 32'h12);
    endtask

    task automatic t_stores();
        do_store("R6 sb lane1", 2'd0, 32'h21, 16'h0000, 32'h1234_565A, 32'h21, 4'b0010, 32'h5A5A_5A5A);
        do_store("R6 sh high", 2'd1, 32'h20, 16'h0002, 32'hCAFE_BEEF, 32'h22, 4'b1100, 32'hBEEF_BEEF);
        do_store("R6 sw", 2'd2, 32'h30, 16'hFFF4, 32'h1357_9BDF, 32'h24, 4'b1111, 32'h1357_9BDF);
        do_load("R6 readback merged", 2'd2, 1'b0, 32'h20, 16'h0000, 32'h20, 4'b1111, 32'hBEEF_5A00);
    endtask

    task automatic t_store_faults();
        do_fault("R4 R5 sh odd", 1'b1, 2'd1, 32'h25, 16'h0000, 32'h25);
        do_fault("R4 R5 sw off2", 1'b1, 2'd2, 32'h24, 16'h0002, 32'h26);
        do_load("R5 memory untouched", 2'd2, 1'b0, 32'h24, 16'h0000, 32'h24, 4'b1111, 32'h1357_9BDF);
    endtask

    task automatic t_overlap();
        send(1'b0, 2'd2, 1'b0, 32'h10, 16'h0000, '0);
        @(negedge clk);
        req_valid  = 1'b1;
        req_store  = 1'b0;
        req_size   = 2'd2;
        req_signed = 1'b0;
        req_base   = 32'h24;
        req_offset = 16'h0000;
        check("R9 held off while waiting", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        check("R10 result with ready", {30'd0, ld_valid, req_ready}, 32'd3);
        check("R10 first data", ld_data, 32'hA1B2_83F4);
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 second issued", {31'd0, mem_req_valid}, 32'd1);
        check("R10 second addr", mem_addr, 32'h24);
        @(negedge clk);
        @(negedge clk);
        check("R10 second result", {31'd0, ld_valid}, 32'd1);
        check("R10 second data", ld_data, 32'h1357_9BDF);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_byte_loads();
        t_half_word_loads();
        t_load_faults();
        t_stores();
        t_store_faults();
        t_overlap();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule